// File: doc/BRIEF.md
# I2C Bus Clock and Condition Timer

This block times the SCL and SDA edges for an I2C master. A byte-level engine above it asks for one bus action at a time: a start condition, a repeated start, a stop condition, or a single data bit. The block then drives both lines through open-drain enables, where a 1 pulls the line low. Two 16-bit divisors set the pace. A low phase lasts (low divisor + 1) × 8 input clocks and a high phase lasts (high divisor + 1) × 8 input clocks. SDA only moves in the middle of a low phase, and the block flags that moment to the engine with a one-cycle strobe.

A repeated start holds SCL released for two programmed high times. SDA is pulled low once seven eighths of one high time has passed since SCL was released. For a bit, the level on `sda_in` is captured at the end of the high phase and shown on `rx_bit`. The divider word and the command are captured when a request is accepted. Later changes to either do not affect an action that is already running.

When the block is disabled, both lines are released, the phase timer is cleared and no request is taken. Clock stretching by targets and arbitration between masters are not handled.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, and on the cycle after each clock edge that sees `en` low, `scl_oe`, `sda_oe`, `sda_chg` and `done` are 0. `cmd_ready` is 0 whenever `en` is 0.
- R2: A start request (`cmd` = 0) pulls SDA low on the cycle after it is accepted. It pulls SCL low (H = (div_word[31:16]+1)×8) clocks after that, on the same cycle as `done`.
- R3: A bit request (`cmd` = 2) holds SCL low for L = (div_word[15:0]+1)×8 clocks from acceptance. It then releases SCL for H clocks, and pulls SCL low again on the same cycle as `done`.
- R4: In every low phase, SDA takes its new level (L/2) clocks into the phase, on the same cycle as a one-cycle `sda_chg` pulse while SCL is still pulled low. For a bit request, `sda_oe` becomes the inverse of `cmd_bit`.
- R5: For a bit request, `rx_bit` shows the level of `sda_in` at the end of the high phase, from the cycle on which `done` pulses.
- R6: A repeated start (`cmd` = 1) releases SDA at mid-low and releases SCL after L clocks. It pulls SDA low (div_word[31:16]+1)×7 clocks after SCL is released, and pulls SCL low 2×H clocks after SCL is released, with `done`.
- R7: A stop (`cmd` = 3) pulls SDA low at mid-low and releases SCL after L clocks. It releases SDA H clocks later, with `done`, and leaves SCL released.
- R8: `done` is a single-cycle pulse, one per accepted request. `cmd_ready` is 0 while a request runs, and a request presented while busy is ignored.
- R9: The high divisor is taken from div_word[31:16] and the low divisor from div_word[15:0], both sampled on acceptance. Changing `div_word` during a request does not change its timing.
- R10: Dropping `en` in the middle of a request releases both lines on the next cycle, and that request never produces `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low releases the bus and clears the timer |
| div_word | input | 32 | High divisor in [31:16], low divisor in [15:0] |
| cmd_valid | input | 1 | Request present |
| cmd | input | 2 | 0 start, 1 repeated start, 2 bit, 3 stop |
| cmd_bit | input | 1 | Bit value to send; 1 releases SDA (also used for reads) |
| sda_in | input | 1 | Sensed SDA level |
| cmd_ready | output | 1 | Idle and enabled; a valid request is taken this cycle |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_chg | output | 1 | One-cycle strobe when SDA takes its new level |
| done | output | 1 | One-cycle pulse at the end of a request |
| rx_bit | output | 1 | SDA level captured at the end of the last bit's high phase |

## Verification
A wrong phase state, or a timer that is not cleared between phases, shows up as an SCL edge at the wrong cycle. The error is visible within one low or high period of the request that caused it. A missed terminal count leaves SCL stuck and `done` missing. A wrong stored command inverts SDA at mid-low or moves the repeated-start falling edge. The bench measures each edge in clocks from acceptance for two divider settings, so an off-by-one in the ×8, ×4 or ×7 scaling gives a count that does not match.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int DIV_W = 16;
    localparam int CNT_W = DIV_W + 5;

    typedef enum logic [1:0] {
        CMD_START  = 2'd0,
        CMD_RSTART = 2'd1,
        CMD_BIT    = 2'd2,
        CMD_STOP   = 2'd3
    } i2ct_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } i2ct_phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] hi;
        logic [DIV_W-1:0] lo;
    } div_pair_t;

    // terminal counts (length - 1) of each timed interval
    typedef struct packed {
        logic [CNT_W-1:0] low_mid;
        logic [CNT_W-1:0] low_end;
        logic [CNT_W-1:0] high_end;
        logic [CNT_W-1:0] high_dbl;
        logic [CNT_W-1:0] high_sda;
    } spans_t;

    function automatic logic [CNT_W-1:0] scaled_last(input logic [DIV_W-1:0] d,
                                                     input int unsigned mult);
        logic [CNT_W-1:0] units;
        units = CNT_W'(d) + CNT_W'(1);
        return CNT_W'(units * CNT_W'(mult)) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/i2ct_span_calc.sv
module i2ct_span_calc
    import i2ct_pkg::*;
(
    input  div_pair_t div_q,
    output spans_t    spans
);
    always_comb begin
        spans.low_mid  = scaled_last(div_q.lo, 4);
        spans.low_end  = scaled_last(div_q.lo, 8);
        spans.high_end = scaled_last(div_q.hi, 8);
        spans.high_dbl = scaled_last(div_q.hi, 16);
        spans.high_sda = scaled_last(div_q.hi, 7);
    end
endmodule

// File: rtl/i2ct_phase_timer.sv
module i2ct_phase_timer #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2ct_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] div_word,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd,
    input  logic        cmd_bit,
    input  logic        sda_in,
    output logic        cmd_ready,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        sda_chg,
    output logic        done,
    output logic        rx_bit
);
    i2ct_phase_e      phase;
    i2ct_cmd_e        cur_cmd;
    logic             cur_bit;
    div_pair_t        div_q;
    spans_t           spans;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] high_last;
    logic             accept;
    logic             low_done;
    logic             high_done;
    logic             tmr_clr;

    i2ct_span_calc u_span (
        .div_q (div_q),
        .spans (spans)
    );

    assign cmd_ready = en && (phase == PH_IDLE);
    assign accept    = cmd_ready && cmd_valid;
    assign high_last = (cur_cmd == CMD_RSTART) ? spans.high_dbl : spans.high_end;
    assign low_done  = (phase == PH_LOW)  && (cnt == spans.low_end);
    assign high_done = (phase == PH_HIGH) && (cnt == high_last);
    assign tmr_clr   = !en || accept || low_done || high_done;

    i2ct_phase_timer #(.W(CNT_W)) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .run (phase != PH_IDLE),
        .cnt (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit  <= 1'b0;
            cur_cmd <= CMD_START;
            cur_bit <= 1'b1;
            div_q   <= '0;
        end else if (accept) begin
            cur_cmd <= i2ct_cmd_e'(cmd);
            cur_bit <= cmd_bit;
            div_q   <= div_pair_t'(div_word);
        end else if (high_done && cur_cmd == CMD_BIT) begin
            rx_bit  <= sda_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase   <= PH_IDLE;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            sda_chg <= 1'b0;
            done    <= 1'b0;
        end else begin
            sda_chg <= 1'b0;
            done    <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        if (i2ct_cmd_e'(cmd) == CMD_START) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_HIGH;
                        end else begin
                            phase  <= PH_LOW;
                        end
                    end
                end
                PH_LOW: begin
                    if (cnt == spans.low_mid) begin
                        sda_chg <= 1'b1;
                        unique case (cur_cmd)
                            CMD_BIT:    sda_oe <= !cur_bit;
                            CMD_STOP:   sda_oe <= 1'b1;
                            default:    sda_oe <= 1'b0;
                        endcase
                    end
                    if (low_done) begin
                        scl_oe <= 1'b0;
                        phase  <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (cur_cmd == CMD_RSTART && cnt == spans.high_sda) begin
                        sda_oe <= 1'b1;
                    end
                    if (high_done) begin
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                        if (cur_cmd == CMD_STOP) begin
                            sda_oe <= 1'b0;
                        end else begin
                            scl_oe <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic scl_oe,
    input logic sda_oe,
    input logic sda_chg,
    input logic done
);
    // R10
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_oe && !sda_oe && !done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    chg_under_low_chk: assert property (@(posedge clk) disable iff (rst)
        sda_chg |-> scl_oe);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R1
    ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> en);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_chg   (sda_chg),
    .done      (done)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] div_word = 32'h0000_0001;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        cmd_bit = 1'b1;
    logic        slave_low = 1'b0;
    logic        sda_in;
    logic        cmd_ready, scl_oe, sda_oe, sda_chg, done, rx_bit;

    int checks = 0;
    int errors = 0;
    int t_scl_on, t_scl_off, t_sda_on, t_sda_off, t_done, t_chg, n_done;
    logic rx_at_done, ready_at_poke;

    always #10 clk = ~clk;

    assign sda_in = !(sda_oe || slave_low);

    i2c_scl_timer dut_i (
        .clk(clk), .rst(rst), .en(en), .div_word(div_word),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bit(cmd_bit), .sda_in(sda_in),
        .cmd_ready(cmd_ready), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_chg(sda_chg), .done(done), .rx_bit(rx_bit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // poke_kind: 0 none, 1 present a stop while busy, 2 change div_word
    task automatic run_cmd(input logic [1:0] c, input logic b, input int limit,
                           input int poke, input int poke_kind);
        logic p_scl, p_sda;
        logic [31:0] div_save;
        div_save = div_word;
        t_scl_on = -1; t_scl_off = -1; t_sda_on = -1; t_sda_off = -1;
        t_done = -1; t_chg = -1; n_done = 0; rx_at_done = 1'bx; ready_at_poke = 1'bx;
        @(negedge clk);
        p_scl = scl_oe; p_sda = sda_oe;
        cmd = c; cmd_bit = b; cmd_valid = 1'b1;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (n == 1 || n == poke + 1) cmd_valid = 1'b0;
            if (!p_scl && scl_oe && t_scl_on < 0)  t_scl_on = n;
            if (p_scl && !scl_oe && t_scl_off < 0) t_scl_off = n;
            if (!p_sda && sda_oe && t_sda_on < 0)  t_sda_on = n;
            if (p_sda && !sda_oe && t_sda_off < 0) t_sda_off = n;
            if (sda_chg && t_chg < 0) t_chg = n;
            if (done) begin
                n_done++;
                if (t_done < 0) begin t_done = n; rx_at_done = rx_bit; end
            end
            p_scl = scl_oe; p_sda = sda_oe;
            if (n == poke) begin
                ready_at_poke = cmd_ready;
                if (poke_kind == 1) begin cmd = 2'd3; cmd_valid = 1'b1; end
                if (poke_kind == 2) div_word = 32'h0009_0009;
            end
        end
        div_word = div_save;
    endtask

    task automatic t_reset;
        chk("R1 scl_oe after reset", int'(scl_oe), 0);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 ready while disabled", int'(cmd_ready), 0);
        en = 1'b1;
        @(negedge clk);
        chk("R1 ready once enabled", int'(cmd_ready), 1);
    endtask

    // div A: lo=1 hi=0 -> L=16 half=8 H=8
    task automatic t_start_a;
        run_cmd(2'd0, 1'b1, 20, 0, 0);
        chk("R2 sda low first", t_sda_on, 1);
        chk("R2 scl low after H", t_scl_on, 9);
        chk("R2 done with scl", t_done, 9);
        chk("R8 single done", n_done, 1);
    endtask

    task automatic t_bits_a;
        run_cmd(2'd2, 1'b1, 30, 0, 0);
        chk("R4 sda release mid-low", t_sda_off, 9);
        chk("R4 chg strobe", t_chg, 9);
        chk("R3 scl release after L", t_scl_off, 17);
        chk("R3 scl low after H", t_scl_on, 25);
        chk("R3 done", t_done, 25);
        run_cmd(2'd2, 1'b0, 30, 0, 0);
        chk("R4 sda drive for zero", t_sda_on, 9);
        slave_low = 1'b1;
        run_cmd(2'd2, 1'b1, 30, 0, 0);
        slave_low = 1'b0;
        chk("R5 read low", int'(rx_at_done), 0);
        run_cmd(2'd2, 1'b1, 30, 0, 0);
        chk("R5 read high", int'(rx_at_done), 1);
    endtask

    // div B: lo=2 hi=1 -> L=24 half=12 H=16 7/8=14
    task automatic t_rstart_stop_b;
        run_cmd(2'd2, 1'b0, 45, 0, 0);
        chk("R9 low field sets L", t_scl_off, 25);
        chk("R9 high field sets H", t_done, 41);
        run_cmd(2'd1, 1'b1, 62, 0, 0);
        chk("R6 sda release mid-low", t_sda_off, 13);
        chk("R6 scl release", t_scl_off, 25);
        chk("R6 sda low at 7/8", t_sda_on, 39);
        chk("R6 scl low at 2H", t_scl_on, 57);
        chk("R6 done", t_done, 57);
        run_cmd(2'd2, 1'b1, 45, 0, 0);
        run_cmd(2'd3, 1'b1, 50, 0, 0);
        chk("R7 sda low mid-low", t_sda_on, 13);
        chk("R7 scl release", t_scl_off, 25);
        chk("R7 sda release after H", t_sda_off, 41);
        chk("R7 done", t_done, 41);
        chk("R7 scl stays released", int'(scl_oe), 0);
        chk("R8 single stop done", n_done, 1);
    endtask

    task automatic t_busy_and_div_b;
        run_cmd(2'd0, 1'b1, 25, 0, 0);
        chk("R2 scl low after H (div B)", t_scl_on, 17);
        run_cmd(2'd2, 1'b0, 50, 5, 1);
        chk("R8 not ready while busy", int'(ready_at_poke), 0);
        chk("R8 bit timing kept", t_done, 41);
        chk("R8 one done only", n_done, 1);
        chk("R8 stop ignored, scl still low", int'(scl_oe), 1);
        run_cmd(2'd2, 1'b1, 50, 3, 2);
        chk("R9 mid change ignored low", t_scl_off, 25);
        chk("R9 mid change ignored high", t_done, 41);
    endtask

    task automatic t_disable;
        int dn;
        dn = 0;
        @(negedge clk);
        cmd = 2'd2; cmd_bit = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 scl held before disable", int'(scl_oe), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R10 scl released", int'(scl_oe), 0);
        chk("R10 sda released", int'(sda_oe), 0);
        chk("R1 ready low when disabled", int'(cmd_ready), 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk("R10 no done after abort", dn, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R10 ready after re-enable", int'(cmd_ready), 1);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        div_word = {16'd0, 16'd1};
        t_start_a();
        t_bits_a();
        div_word = {16'd1, 16'd2};
        t_rstart_stop_b();
        t_busy_and_div_b();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule